// File: doc/BRIEF.md
# Slow-Domain Time Counter Snapshot

This block keeps a free-running time counter in a slow clock domain and lets a host on a fast register bus read it without tearing. The counter is wider than one bus word, so it cannot be read directly: a word-by-word read across a clock boundary could pair the low half of one count with the high half of another. The host instead asks for a snapshot. The request crosses into the slow domain as a toggle. On a slow edge the current count is copied into a holding register and an acknowledge toggle is sent back. In the bus domain the acknowledge is synchronized. When its edge is seen, the held value is copied into bus-side shadow words and a ready flag is set.

The ready flag is also driven out as an interrupt line. It stays set until the host writes a clear. The shadow words do not change between one completed snapshot and the next, so the host can read the low word and then the high word in either order, at any pace. A request made while an earlier one is still in flight is merged into it rather than queued. Completion takes a few slow cycles, set by the synchronizer depth. On each side it is at most two synchronizer delays plus one edge-detect cycle.

Top module: `rtc_snapshot`

## Requirements
- R1: After reset the interrupt line is low and reads of STATUS (address 1), LOW (address 3) and HIGH (address 4) return zero.
- R2: The slow-domain counter is CNT_W bits wide, starts at zero when the slow reset is released, and increases by one on every slow clock edge, modulo 2^CNT_W.
- R3: Writing address 0 with data bit 0 set starts a capture when none is pending. The ready flag reads 0 on the following cycle and rises within 4 slow periods plus 6 bus cycles.
- R4: The captured value, read as LOW (bits WORD_W-1:0 of the count) and HIGH (the remaining CNT_W-WORD_W upper bits, zero-extended), is one single count. That count is not earlier than the count when the request was written and not more than 4 above it.
- R5: The LOW and HIGH read values do not change after a capture completes, including across a ready-flag clear, until the next capture completes.
- R6: The interrupt line and STATUS bit 0 both equal the ready flag. STATUS bit 1 reads 1 while a capture is pending.
- R7: Writing address 2 with data bit 0 set clears the ready flag on the next cycle. A write there with bit 0 clear has no effect.
- R8: A request written while a capture is pending is merged: only one capture completes, and no second ready event follows.
- R9: A write to address 0 with bit 0 clear starts nothing. Reads of unmapped addresses (5, 6, 7) return zero. Read data appears one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| slow_clk | input | 1 | Slow time-base clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | WORD_W | Write data |
| rdata | output | WORD_W | Registered read data |
| irq | output | 1 | Snapshot-ready interrupt (level) |

## Verification
If a toggle or edge detector is left in a wrong state, the fault shows up as a ready event that never arrives, or as an extra one. The latency bound catches a missing event within a few slow periods of the request. The quiet window after a merged request catches an extra event. If the shadow or holding registers are wrongly updated, the fault shows as a count outside the request window, or as a low/high pair whose combined value jumps by a multiple of 2^WORD_W. The snapshot sweep crosses several low-word wraps, so such a fault is seen at the first affected read.

// File: rtl/rtc_snapshot_pkg.sv
package rtc_snapshot_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_STATUS = 3'd1,
    REG_CLEAR  = 3'd2,
    REG_LOW    = 3'd3,
    REG_HIGH   = 3'd4
  } reg_addr_e;
  localparam int ST_READY_BIT   = 0;
  localparam int ST_PENDING_BIT = 1;
endpackage

// File: rtl/rtcsnap_sync.sv
module rtcsnap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate
  assign q = chain[STAGES-1];
endmodule

// File: rtl/rtcsnap_slow.sv
module rtcsnap_slow #(
  parameter int CNT_W       = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic             slow_clk,
  input  logic             slow_rst,
  input  logic             req_tog,
  output logic [CNT_W-1:0] hold,
  output logic             ack_tog
);
  logic [CNT_W-1:0] count;
  logic             req_sync;
  logic             req_seen;
  logic             cap;

  rtcsnap_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(slow_clk), .rst(slow_rst), .d(req_tog), .q(req_sync)
  );

  assign cap = req_sync ^ req_seen;

  always_ff @(posedge slow_clk) begin
    if (slow_rst) begin
      count    <= '0;
      hold     <= '0;
      req_seen <= 1'b0;
      ack_tog  <= 1'b0;
    end else begin
      count    <= count + 1'b1;
      req_seen <= req_sync;
      if (cap) begin
        hold    <= count;
        ack_tog <= ~ack_tog;
      end
    end
  end

  // R4: holding register only moves on a capture edge
  a_r4_hold_stable: assert property (@(posedge slow_clk) disable iff (slow_rst)
    !cap |=> $stable(hold));
  // R8: one acknowledge per observed request edge
  a_r8_ack_only_on_capture: assert property (@(posedge slow_clk) disable iff (slow_rst)
    !cap |=> $stable(ack_tog));
endmodule

// File: rtl/rtcsnap_regs.sv
module rtcsnap_regs
  import rtc_snapshot_pkg::*;
#(
  parameter int CNT_W       = 48,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq,
  output logic              req_tog,
  input  logic [CNT_W-1:0]  hold,
  input  logic              ack_tog
);
  localparam int HI_W = CNT_W - WORD_W;

  logic              ack_sync;
  logic              ack_seen;
  logic              done;
  logic              pending;
  logic              ready;
  logic [WORD_W-1:0] shadow_lo;
  logic [HI_W-1:0]   shadow_hi;
  logic              req_wr;
  logic              clr_wr;
  logic              accept;
  logic [WORD_W-1:0] hi_ext;
  logic [WORD_W-1:0] status_w;
  logic [WORD_W-1:0] rd_mux;

  rtcsnap_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_tog), .q(ack_sync)
  );

  assign done   = ack_sync ^ ack_seen;
  assign req_wr = wr_en && (addr == REG_CTRL) && wdata[0];
  assign clr_wr = wr_en && (addr == REG_CLEAR) && wdata[0];
  assign accept = req_wr && (!pending || done);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_seen  <= 1'b0;
      req_tog   <= 1'b0;
      pending   <= 1'b0;
      ready     <= 1'b0;
      shadow_lo <= '0;
      shadow_hi <= '0;
    end else begin
      ack_seen <= ack_sync;
      if (done) begin
        shadow_lo <= hold[WORD_W-1:0];
        shadow_hi <= hold[CNT_W-1:WORD_W];
      end
      if (accept) begin
        req_tog <= ~req_tog;
        pending <= 1'b1;
        ready   <= 1'b0;
      end else if (done) begin
        pending <= 1'b0;
        ready   <= 1'b1;
      end else if (clr_wr) begin
        ready   <= 1'b0;
      end
    end
  end

  always_comb begin
    hi_ext = '0;
    hi_ext[HI_W-1:0] = shadow_hi;
    status_w = '0;
    status_w[ST_READY_BIT]   = ready;
    status_w[ST_PENDING_BIT] = pending;
    case (addr)
      REG_STATUS: rd_mux = status_w;
      REG_LOW:    rd_mux = shadow_lo;
      REG_HIGH:   rd_mux = hi_ext;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign irq = ready;

  // R7: clear without competing event drops the flag
  a_r7_clear_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !done && !accept) |=> !ready);
  // R8: request during pending capture does not send a new toggle
  a_r8_merge_no_toggle: assert property (@(posedge clk) disable iff (rst)
    (req_wr && pending && !done) |=> $stable(req_tog));
  // R3: ready only rises after a synchronized acknowledge
  a_r3_ready_from_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(done));
  // R3: an accepted request lowers ready
  a_r3_request_lowers_ready: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ready && pending);
  // R5: shadow words hold between acknowledges
  a_r5_shadow_stable: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(shadow_lo) && $stable(shadow_hi)));
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import rtc_snapshot_pkg::*;
#(
  parameter int CNT_W       = 48,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_clk,
  input  logic              slow_rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);
  logic             req_tog;
  logic             ack_tog;
  logic [CNT_W-1:0] hold;

  initial begin
    if (CNT_W <= WORD_W || CNT_W > 2 * WORD_W)
      $error("rtc_snapshot: CNT_W must lie in (WORD_W, 2*WORD_W]");
  end

  rtcsnap_regs #(.CNT_W(CNT_W), .WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .req_tog(req_tog),
    .hold(hold), .ack_tog(ack_tog)
  );

  rtcsnap_slow #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_slow (
    .slow_clk(slow_clk), .slow_rst(slow_rst), .req_tog(req_tog),
    .hold(hold), .ack_tog(ack_tog)
  );
endmodule

// File: tb/rtc_snapshot_bench.sv
`timescale 1ns/1ps
module rtc_snapshot_bench;
  localparam int CNT_W  = 20;
  localparam int WORD_W = 12;
  localparam int HI_W   = CNT_W - WORD_W;

  logic clk = 0, slow_clk = 0, rst = 1, slow_rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] addr = '0;
  logic [WORD_W-1:0] wdata = '0;
  logic [WORD_W-1:0] rdata;
  logic irq;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [CNT_W-1:0] ref_cnt;

  always #4    clk = ~clk;
  always #18.5 slow_clk = ~slow_clk;

  rtc_snapshot #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_rtc_snapshot (
    .clk(clk), .rst(rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  // bench time base: slow edges since slow reset release
  always @(posedge slow_clk) begin
    if (slow_rst) ref_cnt <= '0;
    else          ref_cnt <= ref_cnt + 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [WORD_W-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [WORD_W-1:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // request, returning the reference count at the write and latency in bus cycles
  task automatic request(output logic [CNT_W-1:0] start, output int lat);
    @(negedge clk); wr_en = 1; addr = 3'd0; wdata = 1; start = ref_cnt;
    @(negedge clk); wr_en = 0; wdata = '0;
    lat = 1;
    while (!irq && lat < 200) begin @(negedge clk); lat++; end
  endtask

  task automatic read_value(output logic [CNT_W-1:0] v);
    logic [WORD_W-1:0] lo, hi;
    rd(3'd3, lo);
    rd(3'd4, hi);
    check("R4 high word upper bits zero", longint'(hi >> HI_W), 0);
    v = {hi[HI_W-1:0], lo};
  endtask

  initial begin
    logic [WORD_W-1:0] d;
    logic [CNT_W-1:0] start, v, v2, prev;
    int lat;
    idle(20);
    rst = 0; slow_rst = 0;
    idle(2);
    // R1 reset state
    check("R1 irq after reset", irq, 0);
    rd(3'd1, d); check("R1 STATUS after reset", d, 0);
    rd(3'd3, d); check("R1 LOW after reset", d, 0);
    rd(3'd4, d); check("R1 HIGH after reset", d, 0);
    // R9 unmapped reads and non-request write
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); check("R9 unmapped read zero", d, 0);
    end
    wr(3'd0, 12'h002);
    idle(40);
    check("R9 write without bit0 starts nothing", irq, 0);
    rd(3'd1, d); check("R9 no pending after bit0-clear write", d, 0);

    prev = '0;
    for (int i = 0; i < 50; i++) begin
      request(start, lat);
      check("R3 ready within bound", longint'(lat <= 25), 1);
      rd(3'd1, d);
      check("R6 STATUS ready bit and irq", d[0], 1);
      check("R6 irq equals ready", irq, 1);
      check("R6 no pending after completion", d[1], 0);
      read_value(v);
      check("R4 count not before request", longint'(v - start <= 4), 1);
      check("R2 count advances across snapshots", longint'(v > prev || i == 0), 1);
      prev = v;
      idle(700 + 31 * i);
      read_value(v2);
      check("R5 value held while ready", v2, v);
      wr(3'd2, 12'h000);
      check("R7 clear without bit0 ignored", irq, 1);
      wr(3'd2, 12'h001);
      check("R7 clear lowers irq", irq, 0);
      rd(3'd1, d); check("R7 STATUS ready cleared", d[0], 0);
      read_value(v2);
      check("R5 value held across clear", v2, v);
      idle(300 + 17 * i);
    end

    // R3 request lowers ready immediately; R6 pending bit
    request(start, lat);
    @(negedge clk); wr_en = 1; addr = 3'd0; wdata = 1; start = ref_cnt;
    @(negedge clk); wr_en = 0; wdata = '0; rd_en = 1; addr = 3'd1;
    @(negedge clk); rd_en = 0;
    check("R3 ready reads 0 after new request", rdata[0], 0);
    check("R6 pending bit set during capture", rdata[1], 1);
    // R8 merge: second request while pending
    wr(3'd0, 12'h001);
    lat = 0;
    while (!irq && lat < 200) begin @(negedge clk); lat++; end
    check("R8 merged capture completes", irq, 1);
    read_value(v);
    check("R8 merged value within window", longint'(v - start <= 6), 1);
    wr(3'd2, 12'h001);
    idle(200);
    check("R8 no second ready event", irq, 0);
    read_value(v2);
    check("R8 value unchanged after merge", v2, v);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule